// File: doc/BRIEF.md
# EPROM Pulse Programming Sequencer

This block writes a byte image into a UV-erasable, byte-wide EPROM through its pins and then proves the result. After a start request it visits every address from zero to the top of the array. At each address it sets up the address, the data and the raised supplies, and drops chip-enable for one timed program pulse. It then reads the byte back. If the byte matches the image it moves on; if not it pulses again, up to a fixed cap. A byte that is still wrong after the last allowed pulse fails the whole device at once.

Once every byte has been programmed, the sequencer returns the supply to its normal level, removes the program voltage and reads the full array in ascending order. Each byte is compared with the image. The device passes only if every comparison holds. The image comes from a source port that the sequencer indexes with the current address. The analog supplies are represented by two level-select flags, and all waits are counted in clock cycles derived from a clock-frequency parameter.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, busy, done, pass and fail are 0, the sequencer does not drive the data bus, chip-enable and output-enable are high (inactive), and both supply flags are low.
- R2: Each program pulse holds chip-enable low for exactly ceil(PULSE_NS x CLK_HZ / 1e9) cycles, while the program-voltage flag, the raised-supply flag and the data-bus drive are all active and output-enable is high.
- R3: Address, data, program voltage and raised supply are stable for at least ceil(SETUP_NS) cycles before chip-enable falls for a pulse. Data and program voltage stay for at least ceil(HOLD_NS) cycles after it rises.
- R4: After every pulse the byte is read back with chip-enable and output-enable low for ceil(VERIFY_NS) cycles, and it is sampled on the last of those cycles. A match ends work on that address; the byte receives exactly as many pulses as it needed.
- R5: A byte may receive at most MAX_PULSES pulses. A byte that matches on exactly the last allowed pulse is accepted. A byte that still mismatches after it ends the run with fail, and no later address is pulsed and no final pass is run.
- R6: The data bus is released whenever output-enable is low. Between the end of the hold and the read, all pins stay idle for ceil(SETUP_NS) cycles.
- R7: The final pass lowers both supply flags, then reads every address once in ascending order and compares it with the image. pass=1 only if all bytes match; otherwise fail=1, and the pass still covers every address.
- R8: done is high for exactly one cycle. pass and fail are valid in that cycle, are never both 1, and stay unchanged until the next accepted start, which clears both.
- R9: A start request while busy is ignored. The run continues unchanged and produces a single done.
- R10: Every wait is rounded up to whole cycles: with a 1000 ns verify wait at 2.5 MHz, each final-pass read window lasts 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Latched verdict: device good |
| fail | output | 1 | Latched verdict: device failed |
| src_addr | output | ADDR_W | Image index (current address) |
| src_data | input | DATA_W | Image byte for src_addr |
| ep_addr | output | ADDR_W | EPROM address pins |
| ep_dq_out | output | DATA_W | Data driven onto the EPROM bus |
| ep_dq_oe | output | 1 | Data-bus drive enable |
| ep_dq_in | input | DATA_W | Data read from the EPROM bus |
| ep_ce_n | output | 1 | Chip-enable, active low, carries the program pulse |
| ep_oe_n | output | 1 | Output-enable, active low, for reads |
| ep_vpp_on | output | 1 | Program-voltage level select |
| ep_vcc_hi | output | 1 | Raised-supply level select |

## Verification
The bench builds the block with ADDR_W=3 and CLK_HZ=2.5 MHz and keeps the default time values. A pulse is then 250 cycles, setup and hold are 5, and the verify wait of 2.5 cycles rounds up to 3. An eight-byte array makes the ten-pulse boundary, the overrun of the cap, the final-pass failure and a start request during a run all reachable within a few thousand cycles each. The behavioural EPROM presents valid data only after the required read time, so an early sample shows up as wrong data.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_P_SETUP,
    ST_P_PULSE,
    ST_P_HOLD,
    ST_P_RECOV,
    ST_P_READ,
    ST_F_SETTLE,
    ST_F_READ,
    ST_FINISH
  } seq_state_e;

  // Convert a duration in ns to clock cycles, rounding up, never below one.
  function automatic int unsigned wait_cycles(input longint unsigned ns,
                                              input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/eprom_wait_timer.sv
module eprom_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/eprom_pulse_tracker.sv
module eprom_pulse_tracker #(
  parameter int unsigned MAX_PULSES = 10
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic clear,
  input  logic incr,
  output logic at_limit
);
  localparam int unsigned PC_W = $clog2(MAX_PULSES + 1);

  logic [PC_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = clear | incr;
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == PC_W'(MAX_PULSES));

  assert_pulse_cap_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    cnt_q <= PC_W'(MAX_PULSES));
endmodule

// File: rtl/eprom_addr_step.sv
module eprom_addr_step #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              is_last
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = clear | step;
    addr_d  = clear ? '0 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr    = addr_q;
  assign is_last = (addr_q == '1);
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_prog_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 16,
  parameter int unsigned      DATA_W     = 8,
  parameter longint unsigned  CLK_HZ     = 250_000_000,
  parameter int unsigned      PULSE_NS   = 100_000,
  parameter int unsigned      SETUP_NS   = 2_000,
  parameter int unsigned      HOLD_NS    = 2_000,
  parameter int unsigned      VERIFY_NS  = 1_000,
  parameter int unsigned      MAX_PULSES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] ep_addr,
  output logic [DATA_W-1:0] ep_dq_out,
  output logic              ep_dq_oe,
  input  logic [DATA_W-1:0] ep_dq_in,
  output logic              ep_ce_n,
  output logic              ep_oe_n,
  output logic              ep_vpp_on,
  output logic              ep_vcc_hi
);
  localparam int unsigned PULSE_CYC  = wait_cycles(PULSE_NS, CLK_HZ);
  localparam int unsigned SETUP_CYC  = wait_cycles(SETUP_NS, CLK_HZ);
  localparam int unsigned HOLD_CYC   = wait_cycles(HOLD_NS, CLK_HZ);
  localparam int unsigned VERIFY_CYC = wait_cycles(VERIFY_NS, CLK_HZ);
  localparam int unsigned MAX_A      = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int unsigned MAX_B      = (HOLD_CYC > VERIFY_CYC) ? HOLD_CYC : VERIFY_CYC;
  localparam int unsigned MAX_WAIT   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TMR_W      = $clog2(MAX_WAIT + 1);

  localparam logic [TMR_W-1:0] LD_PULSE  = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] LD_SETUP  = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] LD_HOLD   = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] LD_VERIFY = TMR_W'(VERIFY_CYC - 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  seq_state_e        state_q, state_d;
  logic              tmr_load, tmr_done;
  logic [TMR_W-1:0]  tmr_val;
  logic              pc_clr, pc_inc, pc_limit;
  logic              ad_clr, ad_step, ad_last;
  logic [ADDR_W-1:0] cur_addr;
  logic              bad_q, bad_d, bad_en;
  logic              pass_q, pass_d, fail_q, fail_d, verdict_en;
  logic              byte_ok;

  eprom_wait_timer #(.CNT_W(TMR_W)) u_timer (
    .clk(clk), .rst_sn(rst_sn), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_done));

  eprom_pulse_tracker #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk(clk), .rst_sn(rst_sn), .clear(pc_clr), .incr(pc_inc),
    .at_limit(pc_limit));

  eprom_addr_step #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_sn(rst_sn), .clear(ad_clr), .step(ad_step),
    .addr(cur_addr), .is_last(ad_last));

  assign byte_ok = (ep_dq_in == src_data);

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    pc_clr     = 1'b0;
    pc_inc     = 1'b0;
    ad_clr     = 1'b0;
    ad_step    = 1'b0;
    bad_en     = 1'b0;
    bad_d      = 1'b0;
    verdict_en = 1'b0;
    pass_d     = 1'b0;
    fail_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d    = ST_P_SETUP;
        tmr_load   = 1'b1;
        tmr_val    = LD_SETUP;
        ad_clr     = 1'b1;
        pc_clr     = 1'b1;
        bad_en     = 1'b1;
        verdict_en = 1'b1;
      end
      ST_P_SETUP: if (tmr_done) begin
        state_d  = ST_P_PULSE;
        tmr_load = 1'b1;
        tmr_val  = LD_PULSE;
        pc_inc   = 1'b1;
      end
      ST_P_PULSE: if (tmr_done) begin
        state_d  = ST_P_HOLD;
        tmr_load = 1'b1;
        tmr_val  = LD_HOLD;
      end
      ST_P_HOLD: if (tmr_done) begin
        state_d  = ST_P_RECOV;
        tmr_load = 1'b1;
        tmr_val  = LD_SETUP;
      end
      ST_P_RECOV: if (tmr_done) begin
        state_d  = ST_P_READ;
        tmr_load = 1'b1;
        tmr_val  = LD_VERIFY;
      end
      ST_P_READ: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = LD_SETUP;
        if (byte_ok) begin
          pc_clr = 1'b1;
          if (ad_last) begin
            state_d = ST_F_SETTLE;
            ad_clr  = 1'b1;
          end else begin
            state_d = ST_P_SETUP;
            ad_step = 1'b1;
          end
        end else if (pc_limit) begin
          state_d    = ST_FINISH;
          verdict_en = 1'b1;
          fail_d     = 1'b1;
        end else begin
          state_d = ST_P_SETUP;
        end
      end
      ST_F_SETTLE: if (tmr_done) begin
        state_d  = ST_F_READ;
        tmr_load = 1'b1;
        tmr_val  = LD_VERIFY;
      end
      ST_F_READ: if (tmr_done) begin
        if (!byte_ok) begin
          bad_en = 1'b1;
          bad_d  = 1'b1;
        end
        if (ad_last) begin
          state_d    = ST_FINISH;
          verdict_en = 1'b1;
          pass_d     = !(bad_q || !byte_ok);
          fail_d     = bad_q || !byte_ok;
        end else begin
          ad_step  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_VERIFY;
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      bad_q   <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (bad_en) bad_q <= bad_d;
      if (verdict_en) begin
        pass_q <= pass_d;
        fail_q <= fail_d;
      end
    end
  end

  // Pin decode from the registered state.
  always_comb begin
    ep_dq_oe  = (state_q == ST_P_SETUP) || (state_q == ST_P_PULSE) ||
                (state_q == ST_P_HOLD);
    ep_vpp_on = ep_dq_oe;
    ep_vcc_hi = ep_dq_oe || (state_q == ST_P_RECOV) || (state_q == ST_P_READ);
    ep_oe_n   = !((state_q == ST_P_READ) || (state_q == ST_F_READ));
    ep_ce_n   = !((state_q == ST_P_PULSE) || !ep_oe_n);
  end

  assign ep_addr   = cur_addr;
  assign src_addr  = cur_addr;
  assign ep_dq_out = src_data;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FINISH);
  assign pass      = pass_q;
  assign fail      = fail_q;

  assert_pulse_supplies_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ep_ce_n && ep_oe_n) |-> (ep_vpp_on && ep_vcc_hi && ep_dq_oe));

  assert_setup_stable_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    ($fell(ep_ce_n) && ep_vpp_on) |->
      ($stable(ep_addr) && $stable(ep_dq_out) && $past(ep_vpp_on)));

  assert_bus_release_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    !ep_oe_n |-> !ep_dq_oe);

  assert_final_supply_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ep_oe_n && !ep_vcc_hi) |-> !ep_vpp_on);

  assert_verdict_excl_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    !(pass && fail));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);

  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && !done) |=> busy);
endmodule

// File: tb/eprom_prog_seq_bench.sv
module eprom_prog_seq_bench;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int NADDR = 1 << AW;
  // Expected cycle counts at 2.5 MHz, rounded up.
  localparam int PULSE_C = 250;
  localparam int SETUP_C = 5;
  localparam int HOLD_C  = 5;
  localparam int VER_C   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, pass, fail;
  logic [AW-1:0] src_addr, ep_addr;
  logic [DW-1:0] src_data, ep_dq_out, ep_dq_in;
  logic ep_dq_oe, ep_ce_n, ep_oe_n, ep_vpp_on, ep_vcc_hi;

  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // Scenario knobs.
  logic [7:0] seed = 8'h21;
  int hard_addr = -1;
  int hard_need = 1;
  int leak_addr = -1;
  logic mdl_clear = 1'b0;

  function automatic logic [7:0] img_byte(input logic [AW-1:0] a);
    return 8'({5'd0, a} * 8'd37 + seed);
  endfunction

  function automatic int need_of(input logic [AW-1:0] a);
    if (int'(a) == hard_addr) return hard_need;
    return (int'(a) % 3) + 1;
  endfunction

  assign src_data = img_byte(src_addr);

  eprom_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_HZ(64'd2_500_000)) u_eprom_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .src_addr(src_addr), .src_data(src_data),
    .ep_addr(ep_addr), .ep_dq_out(ep_dq_out), .ep_dq_oe(ep_dq_oe),
    .ep_dq_in(ep_dq_in), .ep_ce_n(ep_ce_n), .ep_oe_n(ep_oe_n),
    .ep_vpp_on(ep_vpp_on), .ep_vcc_hi(ep_vcc_hi));

  // Behavioural EPROM and pin monitor.
  logic [7:0] mem [0:NADDR-1];
  int hits [0:NADDR-1];
  logic pce = 1'b1, pvcc = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pdq = '0;
  int stab = 0, lowcnt = 0, hcnt = 0, rdcnt = 0, fwin = 0;
  logic hold_on = 1'b0;
  int err_w = 0, err_su = 0, err_hd = 0, cont = 0, err_win = 0, err_ord = 0, fin_reads = 0;

  logic rd_act;
  assign rd_act   = !ep_ce_n && !ep_oe_n;
  assign ep_dq_in = (rd_act && rdcnt >= VER_C - 1) ? mem[ep_addr] : (img_byte(ep_addr) ^ 8'h80);

  always @(posedge clk) begin
    logic pc, chg, fin_act;
    pc      = ep_vpp_on && ep_dq_oe && ep_vcc_hi;
    chg     = (ep_addr != paddr) || (ep_dq_out != pdq);
    fin_act = rd_act && !ep_vcc_hi;
    if (mdl_clear) begin
      for (int i = 0; i < NADDR; i++) begin
        mem[i]  <= 8'hFF;
        hits[i] <= 0;
      end
      stab <= 0; lowcnt <= 0; hcnt <= 0; hold_on <= 1'b0; rdcnt <= 0; fwin <= 0;
      err_w <= 0; err_su <= 0; err_hd <= 0; cont <= 0; err_win <= 0; err_ord <= 0;
      fin_reads <= 0;
    end else begin
      if (pc && ep_ce_n) stab <= chg ? 1 : stab + 1;
      else if (ep_ce_n) stab <= 0;
      if (!ep_ce_n && pce && ep_oe_n && stab < SETUP_C) err_su <= err_su + 1;
      if (!ep_ce_n && ep_oe_n) begin
        lowcnt <= lowcnt + 1;
        if (!pc) err_w <= err_w + 1;
      end else if (lowcnt != 0) begin
        if (lowcnt != PULSE_C) err_w <= err_w + 1;
        hits[ep_addr] <= hits[ep_addr] + 1;
        if (hits[ep_addr] + 1 >= need_of(ep_addr)) mem[ep_addr] <= mem[ep_addr] & ep_dq_out;
        lowcnt  <= 0;
        hold_on <= 1'b1;
        hcnt    <= pc ? 1 : 0;
      end else if (hold_on) begin
        if (pc && ep_ce_n && !chg) hcnt <= hcnt + 1;
        else begin
          hold_on <= 1'b0;
          if (hcnt < HOLD_C) err_hd <= err_hd + 1;
        end
      end
      if (ep_dq_oe && !ep_oe_n) cont <= cont + 1;
      if (rd_act) rdcnt <= (rdcnt != 0 && ep_addr == paddr) ? rdcnt + 1 : 1;
      else rdcnt <= 0;
      if (fwin != 0 && (!fin_act || ep_addr != paddr)) begin
        if (fwin != VER_C) err_win <= err_win + 1;
        if (int'(paddr) != fin_reads) err_ord <= err_ord + 1;
        fin_reads <= fin_reads + 1;
      end
      if (fin_act) fwin <= (fwin != 0 && ep_addr == paddr) ? fwin + 1 : 1;
      else fwin <= 0;
      if (pvcc && !ep_vcc_hi && leak_addr >= 0)
        mem[AW'(leak_addr)] <= mem[AW'(leak_addr)] ^ 8'h01;
    end
    pce   <= ep_ce_n;
    paddr <= ep_addr;
    pdq   <= ep_dq_out;
    pvcc  <= ep_vcc_hi;
  end

  // Watchdog: an expired run counts as one failed check.
  int wd_cyc = 0;
  always @(posedge clk) begin
    wd_cyc <= wd_cyc + 1;
    if (wd_cyc == 190_000) begin
      $display("FAIL watchdog: actual %0d cycles expected fewer", wd_cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    @(negedge clk) mdl_clear = 1'b1;
    @(negedge clk) mdl_clear = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // Waits for done; counts done cycles including four after the first.
  task automatic wait_done(input bit poke, output int dcnt, output logic p, output logic f);
    int n;
    n = 0; dcnt = 0; p = 1'b0; f = 1'b0;
    while (n < 60_000 && dcnt == 0) begin
      @(negedge clk);
      n++;
      start = (poke && (n == 700 || n == 2000)) ? 1'b1 : 1'b0;
      if (done) begin
        dcnt = 1; p = pass; f = fail;
      end
    end
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done) dcnt++;
    end
  endtask

  task automatic check_timing(input string tag);
    chk("R2", {tag, " pulse width/supplies"}, err_w, 0);
    chk("R3", {tag, " setup"}, err_su, 0);
    chk("R3", {tag, " hold"}, err_hd, 0);
    chk("R6", {tag, " bus contention"}, cont, 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "pass|fail", int'(pass | fail), 0);
    chk("R1", "idle pins ce_n,oe_n,oe,vpp,vcc", int'({ep_ce_n, ep_oe_n, ep_dq_oe, ep_vpp_on, ep_vcc_hi}), 5'b11000);
  endtask

  task automatic t_normal();
    int d; logic p, f; int good_img, good_hits;
    seed = 8'h21; hard_addr = -1; leak_addr = -1;
    clear_model();
    kick();
    wait_done(1'b0, d, p, f);
    chk("R8", "done width", d, 1);
    chk("R7", "pass", int'(p), 1);
    chk("R7", "fail", int'(f), 0);
    good_img = 0; good_hits = 0;
    for (int a = 0; a < NADDR; a++) begin
      if (mem[a] == img_byte(AW'(a))) good_img++;
      if (hits[a] == need_of(AW'(a))) good_hits++;
    end
    chk("R4", "bytes programmed", good_img, NADDR);
    chk("R4", "pulses per byte equal need", good_hits, NADDR);
    check_timing("normal");
    chk("R7", "final reads", fin_reads, NADDR);
    chk("R7", "final read order", err_ord, 0);
    chk("R10", "final read window length", err_win, 0);
  endtask

  task automatic t_ten_pulses();
    int d; logic p, f;
    seed = 8'h4C; hard_addr = 5; hard_need = 10; leak_addr = -1;
    clear_model();
    kick();
    wait_done(1'b0, d, p, f);
    chk("R5", "pass at cap", int'(p), 1);
    chk("R5", "pulses at hard byte", hits[5], 10);
    chk("R5", "next byte handled", hits[6], need_of(3'd6));
    check_timing("ten");
  endtask

  task automatic t_over_cap();
    int d; logic p, f;
    seed = 8'h4C; hard_addr = 5; hard_need = 11; leak_addr = -1;
    clear_model();
    kick();
    wait_done(1'b0, d, p, f);
    chk("R5", "fail over cap", int'(f), 1);
    chk("R5", "pass over cap", int'(p), 0);
    chk("R5", "pulses capped", hits[5], 10);
    chk("R5", "later byte untouched", hits[6], 0);
    chk("R5", "no final pass", fin_reads, 0);
    chk("R8", "done width on fail", d, 1);
  endtask

  task automatic t_final_mismatch();
    int d; logic p, f;
    seed = 8'h13; hard_addr = -1; leak_addr = 2;
    clear_model();
    kick();
    wait_done(1'b0, d, p, f);
    chk("R7", "fail on final mismatch", int'(f), 1);
    chk("R7", "pass on final mismatch", int'(p), 0);
    chk("R7", "all addresses read", fin_reads, NADDR);
    leak_addr = -1;
  endtask

  task automatic t_busy_start();
    int d; logic p, f; int good_hits;
    seed = 8'h6A; hard_addr = -1; leak_addr = -1;
    clear_model();
    kick();
    wait_done(1'b1, d, p, f);
    chk("R9", "single done with start while busy", d, 1);
    chk("R9", "pass", int'(p), 1);
    good_hits = 0;
    for (int a = 0; a < NADDR; a++) if (hits[a] == need_of(AW'(a))) good_hits++;
    chk("R9", "pulse counts unchanged", good_hits, NADDR);
    chk("R9", "one final pass", fin_reads, NADDR);
  endtask

  task automatic t_latch();
    int d; logic p, f;
    seed = 8'h21; hard_addr = -1; leak_addr = -1;
    clear_model();
    kick();
    wait_done(1'b0, d, p, f);
    repeat (20) @(negedge clk);
    chk("R8", "pass held after done", int'(pass), 1);
    chk("R8", "fail held after done", int'(fail), 0);
    kick();
    chk("R8", "verdict cleared by start", int'(pass | fail), 0);
    chk("R8", "busy after start", int'(busy), 1);
    clear_model();
    wait_done(1'b0, d, p, f);
  endtask

  initial begin
    for (int i = 0; i < NADDR; i++) begin
      mem[i] = 8'hFF;
      hits[i] = 0;
    end
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_normal();
    t_ten_pulses();
    t_over_cap();
    t_final_mismatch();
    t_busy_start();
    t_latch();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule